// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and End-of-Service Unit

This unit is the processor-facing side of an interrupt controller. It keeps two sets with one bit per source. The pending-for-CPU ("raised") set holds sources that were delivered but not yet taken. The in-service set holds sources that the processor has taken and not yet retired. It also holds a task-priority threshold and drives one level-sensitive interrupt request line to the processor.

The source bank supplies the per-source priority, vector, sense (edge or level) and activity flags. It offers deliveries through a request vector. The unit answers acknowledge reads by picking the best raised source and checking it again. It returns that source's vector, or a spurious code when the source is no longer valid. It sends one-cycle strobes back to the source bank to clear that source's activity and pending state. An end-of-service write retires the best in-service source. In the cycle after that write, the unit decides whether the request line must rise again.

A small controller with three states sequences the register port:
- `S_IDLE`: no response is due.
- `S_RDRESP`: the registered read data is valid.
- `S_EOI_CHK`: the request-line recheck after an end-of-service write.

From any state, a read moves the controller to `S_RDRESP`. A write to the end-of-service offset moves it to `S_EOI_CHK`. Any other cycle returns it to `S_IDLE`.

Top module: `cpu_ack_unit`

## Requirements
- R1: After reset the task priority reads 0xF, both sets are empty, `cpu_irq` is low and `rd_valid` is low.
- R2: A write to offset 0x80 stores `bus_wdata[3:0]` as the task priority. Every read returns data with `rd_valid` high exactly one cycle after the request.
- R3: Reading offset 0x80 returns the task priority zero-extended. Offset 0x90 returns the CPU index parameter. Offset 0xB0 returns 0. Any other aligned offset returns 0xFFFFFFFF.
- R4: An access whose address bits [3:0] are nonzero has no effect on any state and reads 0xFFFFFFFF.
- R5: A delivery request for a source is accepted into the raised set only if the source priority is strictly greater than the task priority. `cpu_irq` rises when an accepted priority is strictly greater than the highest priority already raised, or when the raised set was empty.
- R6: The winner of a set is its member with the highest priority. Among equal priorities, the lowest source index wins.
- R7: An acknowledge read (offset 0xA0) with an empty raised set returns the full 32-bit spurious register.
- R8: If the raised winner's activity flag is clear, or its priority is not greater than the task priority, the acknowledge returns `{24'h0, spur_reg[7:0]}` and pulses `clr_active` for that source.
- R9: Otherwise the acknowledge returns the winner's 8-bit vector zero-extended and places the winner in the in-service set.
- R10: Every acknowledge that finds a winner removes it from the raised set. For an edge-sensitive winner (`src_level` = 0), `clr_active` and `clr_pending` both pulse for it, together with the read data. A valid level-sensitive winner pulses neither.
- R11: An acknowledge read drops `cpu_irq` one cycle later, unless a delivery accepted in the same cycle raises it.
- R12: A write to offset 0xB0 removes the highest-priority in-service source (ties go to the lowest index). With an empty in-service set, the write does nothing.
- R13: One cycle after an end-of-service write, `cpu_irq` is set if the highest raised priority exceeds the highest remaining in-service priority. An empty in-service set counts as lower than any priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_req | input | NUM_SRC | Delivery requests from the source bank, one per source |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority, source i at bits [i*PRIO_W +: PRIO_W] |
| src_vec | input | NUM_SRC*8 | Per-source vector, source i at bits [i*8 +: 8] |
| src_level | input | NUM_SRC | 1 = level-sensitive source, 0 = edge-sensitive |
| src_active | input | NUM_SRC | Per-source activity flag |
| spur_reg | input | 32 | Spurious vector register contents |
| bus_rd | input | 1 | Register read request |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | ADDR_W | Register offset within the per-CPU page |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rd_data | output | 32 | Registered read data |
| clr_active | output | NUM_SRC | One-cycle strobe that clears a source's activity flag |
| clr_pending | output | NUM_SRC | One-cycle strobe that clears a source's pending flag |
| cpu_irq | output | 1 | Interrupt request level to the processor |

## Verification
The bench sweeps every pair of task priority and source priority. A design that used `>=` in place of a strict compare would wrongly accept deliveries at equal priority. Tie cases on equal priorities expose a search that keeps the last match, because the acknowledge order would come out reversed. A priority lowered after delivery must give the short spurious code, and an empty set must give the full spurious word. Swapping these two, or dropping the activity strobe, changes the returned data. End-of-service sequences hold mixed in-service and raised priorities. They show whether the wrong in-service member is retired and whether the request line comes back only when the raised maximum beats what remains in service. Misaligned reads and writes must leave the threshold and the raised set unchanged.

// File: rtl/cpu_ack_pkg.sv
package cpu_ack_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RDRESP  = 2'd1,
        S_EOI_CHK = 2'd2
    } ack_state_e;

    localparam logic [7:0] OFF_TPR = 8'h80;
    localparam logic [7:0] OFF_WHO = 8'h90;
    localparam logic [7:0] OFF_ACK = 8'hA0;
    localparam logic [7:0] OFF_EOI = 8'hB0;

endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        members,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [IDX_W-1:0]          idx,
    output logic [PRIO_W-1:0]         prio
);
    // Strictly-greater replacement keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        prio  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (members[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > prio)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/raise_gate.sv
module raise_gate #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4
) (
    input  logic [NUM_SRC-1:0]        raise_req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         task_prio,
    input  logic [NUM_SRC-1:0]        raised,
    input  logic                      raised_found,
    input  logic [PRIO_W-1:0]         raised_prio,
    output logic [NUM_SRC-1:0]        accept,
    output logic                      wake
);
    always_comb begin
        accept = '0;
        wake   = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (raise_req[i] && !raised[i] &&
                prio_flat[i*PRIO_W +: PRIO_W] > task_prio) begin
                accept[i] = 1'b1;
                if (!raised_found || prio_flat[i*PRIO_W +: PRIO_W] > raised_prio) begin
                    wake = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cpu_ack_unit.sv
module cpu_ack_unit
    import cpu_ack_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 12,
    parameter int CPU_ID  = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        raise_req,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC*8-1:0]      src_vec,
    input  logic [NUM_SRC-1:0]        src_level,
    input  logic [NUM_SRC-1:0]        src_active,
    input  logic [31:0]               spur_reg,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic                      rd_valid,
    output logic [31:0]               rd_data,
    output logic [NUM_SRC-1:0]        clr_active,
    output logic [NUM_SRC-1:0]        clr_pending,
    output logic                      cpu_irq
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ADDR_W-1:0] A_TPR = ADDR_W'(OFF_TPR);
    localparam logic [ADDR_W-1:0] A_WHO = ADDR_W'(OFF_WHO);
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(OFF_ACK);
    localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFF_EOI);

    ack_state_e state_q, state_d;

    logic [NUM_SRC-1:0] raised_q, raised_d;
    logic [NUM_SRC-1:0] svc_q, svc_d;
    logic [PRIO_W-1:0]  tpr_q, tpr_d;
    logic               irq_q, irq_d;
    logic [31:0]        rdata_q, rdata_d;
    logic [NUM_SRC-1:0] clra_q, clra_d, clrp_q, clrp_d;

    logic               r_found, s_found;
    logic [IDX_W-1:0]   r_idx, s_idx;
    logic [PRIO_W-1:0]  r_prio, s_prio;
    logic [NUM_SRC-1:0] accept;
    logic               wake;
    logic               aligned, ack_rd, eoi_wr, tpr_wr, win_ok;

    wire unused_wdata = ^bus_wdata[31:PRIO_W];

    prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick_raised (
        .members   (raised_q),
        .prio_flat (src_prio),
        .found     (r_found),
        .idx       (r_idx),
        .prio      (r_prio)
    );

    prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick_svc (
        .members   (svc_q),
        .prio_flat (src_prio),
        .found     (s_found),
        .idx       (s_idx),
        .prio      (s_prio)
    );

    raise_gate #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_gate (
        .raise_req    (raise_req),
        .prio_flat    (src_prio),
        .task_prio    (tpr_q),
        .raised       (raised_q),
        .raised_found (r_found),
        .raised_prio  (r_prio),
        .accept       (accept),
        .wake         (wake)
    );

    // Address decode
    always_comb begin
        aligned = (bus_addr[3:0] == 4'h0);
        ack_rd  = bus_rd && (bus_addr == A_ACK);
        eoi_wr  = bus_wr && (bus_addr == A_EOI);
        tpr_wr  = bus_wr && (bus_addr == A_TPR);
        win_ok  = src_active[r_idx] && (r_prio > tpr_q);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: every state accepts a new request
    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE, S_RDRESP, S_EOI_CHK: begin
                if (bus_rd) begin
                    state_d = S_RDRESP;
                end else if (eoi_wr) begin
                    state_d = S_EOI_CHK;
                end else begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath next values
    always_comb begin
        raised_d = raised_q | accept;
        svc_d    = svc_q;
        tpr_d    = tpr_q;
        clra_d   = '0;
        clrp_d   = '0;
        irq_d    = irq_q;
        rdata_d  = rdata_q;

        if (tpr_wr) begin
            tpr_d = bus_wdata[PRIO_W-1:0];
        end

        if (bus_rd) begin
            rdata_d = 32'hFFFF_FFFF;
            if (aligned) begin
                unique case (bus_addr)
                    A_TPR:   rdata_d = 32'(tpr_q);
                    A_WHO:   rdata_d = 32'(CPU_ID);
                    A_EOI:   rdata_d = 32'h0;
                    A_ACK: begin
                        if (!r_found) begin
                            rdata_d = spur_reg;
                        end else if (!win_ok) begin
                            rdata_d = {24'h0, spur_reg[7:0]};
                        end else begin
                            rdata_d = {24'h0, src_vec[r_idx*8 +: 8]};
                        end
                    end
                    default: rdata_d = 32'hFFFF_FFFF;
                endcase
            end
        end

        if (ack_rd && r_found) begin
            raised_d[r_idx] = 1'b0;
            if (!win_ok) begin
                clra_d[r_idx] = 1'b1;
            end else begin
                svc_d[r_idx] = 1'b1;
            end
            if (!src_level[r_idx]) begin
                clra_d[r_idx] = 1'b1;
                clrp_d[r_idx] = 1'b1;
            end
        end

        if (eoi_wr && s_found) begin
            svc_d[s_idx] = 1'b0;
        end

        if (state_q == S_EOI_CHK && r_found && (!s_found || r_prio > s_prio)) begin
            irq_d = 1'b1;
        end
        if (ack_rd) begin
            irq_d = 1'b0;
        end
        if (wake) begin
            irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q <= '0;
            svc_q    <= '0;
            tpr_q    <= '1;
            irq_q    <= 1'b0;
            rdata_q  <= '0;
            clra_q   <= '0;
            clrp_q   <= '0;
        end else begin
            raised_q <= raised_d;
            svc_q    <= svc_d;
            tpr_q    <= tpr_d;
            irq_q    <= irq_d;
            rdata_q  <= rdata_d;
            clra_q   <= clra_d;
            clrp_q   <= clrp_d;
        end
    end

    // Outputs
    always_comb begin
        rd_valid    = (state_q == S_RDRESP);
        rd_data     = rdata_q;
        clr_active  = clra_q;
        clr_pending = clrp_q;
        cpu_irq     = irq_q;
    end

endmodule

// File: rtl/cpu_ack_unit_chk.sv
module cpu_ack_unit_chk #(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] raise_req,
    input logic               rd_valid,
    input logic [31:0]        rd_data,
    input logic [NUM_SRC-1:0] clr_active,
    input logic [NUM_SRC-1:0] clr_pending,
    input logic               cpu_irq
);
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(8'hA0);

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_valid);

    p_misaligned_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[3:0] != 4'h0) |=> (rd_data == 32'hFFFF_FFFF));

    p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_active));

    p_pending_with_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pending & ~clr_active) == '0);

    p_strobe_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_active != '0) |-> rd_valid);

    p_ack_drops_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ACK && raise_req == '0) |=> !cpu_irq);

endmodule

bind cpu_ack_unit cpu_ack_unit_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .raise_req   (raise_req),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .clr_active  (clr_active),
    .clr_pending (clr_pending),
    .cpu_irq     (cpu_irq)
);

// File: tb/cpu_ack_unit_test.sv
`timescale 1ns/1ps
module cpu_ack_unit_test;
    localparam int N  = 8;
    localparam int PW = 4;
    localparam int AW = 12;
    localparam int ID = 2;
    localparam logic [31:0] SPUR = 32'h0000_0A5C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    raise_req = '0;
    logic [N*PW-1:0] src_prio = '0;
    logic [N*8-1:0]  src_vec = '0;
    logic [N-1:0]    src_level = '0;
    logic [N-1:0]    src_active = '1;
    logic [31:0]     spur_reg = SPUR;
    logic            bus_rd = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic [N-1:0]    clr_active, clr_pending;
    logic            cpu_irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpu_ack_unit #(.NUM_SRC(N), .PRIO_W(PW), .ADDR_W(AW), .CPU_ID(ID)) uut (
        .clk(clk), .rst_n(rst_n), .raise_req(raise_req), .src_prio(src_prio),
        .src_vec(src_vec), .src_level(src_level), .src_active(src_active),
        .spur_reg(spur_reg), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .clr_active(clr_active), .clr_pending(clr_pending), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R2 rd_valid", 32'(rd_valid), 32'd1);
        d = rd_data;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic eoi();
        wr(12'h0B0, 32'h0);
        @(negedge clk);
    endtask

    task automatic raise(input logic [N-1:0] m);
        @(negedge clk);
        raise_req = m;
        @(negedge clk);
        raise_req = '0;
    endtask

    task automatic set_prio(input int i, input logic [PW-1:0] p);
        src_prio[i*PW +: PW] = p;
    endtask

    task automatic ack_expect(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd(12'h0A0, d);
        chk(req, d, exp);
        chk("R11 irq low after ack", 32'(cpu_irq), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < N; i++) src_vec[i*8 +: 8] = 8'h40 + 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(cpu_irq), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        rd(12'h080, d); chk("R1 tpr reset", d, 32'hF);
        rd(12'h0A0, d); chk("R1 R7 empty ack", d, SPUR);

        // R2/R3 register port
        wr(12'h080, 32'hFFFF_FF36);
        rd(12'h080, d); chk("R2 tpr low bits", d, 32'h6);
        rd(12'h090, d); chk("R3 cpu index", d, 32'(ID));
        rd(12'h0B0, d); chk("R3 eoi reads zero", d, 32'h0);
        rd(12'h0C0, d); chk("R3 unmapped", d, 32'hFFFF_FFFF);
        rd(12'h180, d); chk("R3 high page", d, 32'hFFFF_FFFF);

        // R5 sweep: every threshold against every source priority
        for (int t = 0; t < 16; t++) begin
            for (int p = 0; p < 16; p++) begin
                wr(12'h080, 32'(t));
                set_prio(0, PW'(p));
                raise(8'h01);
                chk("R5 accept/irq", 32'(cpu_irq), (p > t) ? 32'd1 : 32'd0);
                rd(12'h0A0, d);
                chk("R5 R9 ack data", d, (p > t) ? 32'h40 : SPUR);
                chk("R10 edge strobes", {30'd0, clr_pending[0], clr_active[0]},
                    (p > t) ? 32'd3 : 32'd0);
                if (p > t) eoi();
            end
        end
        wr(12'h080, 32'h0);

        // R6 ties and ordering
        set_prio(3, 4'd7); set_prio(5, 4'd7); set_prio(6, 4'd9);
        raise(8'b0110_1000);
        chk("R5 irq on raise", 32'(cpu_irq), 32'd1);
        ack_expect("R6 highest first", 32'h46);
        chk("R10 strobe src6", {24'd0, clr_active}, 32'h40);
        ack_expect("R6 tie lowest index", 32'h43);
        ack_expect("R6 tie second", 32'h45);
        ack_expect("R7 empty again", SPUR);
        eoi(); eoi(); eoi();
        chk("R13 no raise when raised empty", 32'(cpu_irq), 32'd0);

        // R8 inactive level source
        set_prio(1, 4'd5); src_active[1] = 1'b0; src_level[1] = 1'b1;
        raise(8'h02);
        rd(12'h0A0, d);
        chk("R8 inactive spurious", d, 32'h5C);
        chk("R8 clr_active", {24'd0, clr_active}, 32'h02);
        chk("R10 level no pending clr", {24'd0, clr_pending}, 32'h0);
        rd(12'h0A0, d); chk("R10 winner removed", d, SPUR);
        src_active[1] = 1'b1;
        raise(8'h02);
        rd(12'h0A0, d);
        chk("R9 level vector", d, 32'h41);
        chk("R10 level valid no strobes", {24'd0, clr_active | clr_pending}, 32'h0);
        eoi();
        src_level[1] = 1'b0;

        // R8 priority dropped below threshold
        set_prio(2, 4'd8);
        wr(12'h080, 32'h2);
        raise(8'h04);
        wr(12'h080, 32'h9);
        rd(12'h0A0, d);
        chk("R8 threshold spurious", d, 32'h5C);
        chk("R10 edge strobes spurious", {16'd0, clr_pending, clr_active}, 32'h0404);
        wr(12'h080, 32'h0);

        // R4 misaligned accesses
        wr(12'h084, 32'h3);
        rd(12'h080, d); chk("R4 tpr untouched", d, 32'h0);
        rd(12'h084, d); chk("R4 misaligned read", d, 32'hFFFF_FFFF);
        set_prio(4, 4'd6);
        raise(8'h10);
        rd(12'h0A8, d); chk("R4 misaligned ack", d, 32'hFFFF_FFFF);
        chk("R4 no strobe", {24'd0, clr_active}, 32'h0);
        chk("R4 irq kept", 32'(cpu_irq), 32'd1);
        ack_expect("R4 raised kept", 32'h44);
        eoi();

        // R12/R13 end-of-service ordering
        set_prio(6, 4'd9); set_prio(5, 4'd7); set_prio(3, 4'd7);
        set_prio(1, 4'd9); set_prio(2, 4'd3);
        raise(8'b0110_0000);
        ack_expect("R9 take src6", 32'h46);
        raise(8'b0000_1000);
        chk("R5 equal prio no wake", 32'(cpu_irq), 32'd0);
        eoi();
        chk("R13 reassert after eoi", 32'(cpu_irq), 32'd1);
        ack_expect("R6 tie src3", 32'h43);
        eoi();
        chk("R13 reassert src5", 32'(cpu_irq), 32'd1);
        ack_expect("R9 take src5", 32'h45);
        raise(8'b0000_0110);
        chk("R5 wake", 32'(cpu_irq), 32'd1);
        ack_expect("R9 take src1", 32'h41);
        eoi();
        chk("R12 R13 low raised no wake", 32'(cpu_irq), 32'd0);
        eoi();
        chk("R12 R13 wake after src5 retired", 32'(cpu_irq), 32'd1);
        ack_expect("R9 take src2", 32'h42);
        eoi();
        chk("R12 empty after all", 32'(cpu_irq), 32'd0);
        eoi();
        chk("R12 eoi on empty", 32'(cpu_irq), 32'd0);
        rd(12'h0A0, d); chk("R12 raised empty", d, SPUR);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule